// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointers

This block carries data words from one clock domain to another through a small dual-port memory. The producer pushes a word with a write strobe on its own clock and sees a full flag; the consumer pops a word with a read strobe on an unrelated clock and sees an empty flag. Each domain has its own active-low asynchronous reset.

Both pointers are kept only in reflected Gray form, one bit wider than the memory address. No binary counter is stored. The memory address is taken straight from the Gray pointer: the top pointer bit is XORed into the bit below it, and the lower bits are used as they are. This gives the same Gray address order in both halves of the pointer cycle. Each pointer reaches the other domain through a two-flop synchroniser, and the flags compare a local pointer with the synchronised remote one.

Top module: `gray_fifo_async`

## Requirements
- R1: Words come out in the order they were written, with no loss or duplication. This holds through repeated wraps of both pointers, which exercises the address folding (address bit ADDR_W-1 = pointer bit ADDR_W XOR pointer bit ADDR_W-1).
- R2: Each pointer is ADDR_W+1 bits wide. It changes in exactly one bit on each accepted operation, following reflected Gray order (for 3 bits: 000, 001, 011, 010, 110, 111, 101, 100, then 000). It is unchanged otherwise.
- R3: rd_empty is 1 exactly when the read pointer equals the write pointer as synchronised into the read domain.
- R4: With the read side idle and settled, wr_full goes to 1 on the write edge that accepts the 2^ADDR_W-th stored word. It is 0 before that edge. The full condition is: write pointer equals the synchronised read pointer with its two top bits inverted.
- R5: A write while wr_full is 1 is ignored. The pointer and the stored contents are unchanged, so draining afterwards yields exactly the earlier words and then empty.
- R6: A read while rd_empty is 1 is ignored. rd_data holds its value and the read pointer does not move, so the next word written is the next word read.
- R7: rd_data is registered. It changes on the read-clock edge that accepts a read and holds otherwise. It is 0 after read reset.
- R8: A written word reaches the read side only through two read-clock flops. rd_empty is still 1 just after the write edge and is 0 within four read-clock cycles.
- R9: Reset puts both pointers at zero. After reset rd_empty is 1 and wr_full is 0, even if words were stored before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | FIFO holds 2^ADDR_W words |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered output word |
| rd_empty | output | 1 | No word available to read |

## Verification
The hardest case to reach is the second half of the pointer cycle, where the folded address must repeat the first half's Gray order. It is reached only after 2^ADDR_W words have passed through. The bench runs long concurrent streams with random gaps on two unrelated clocks, so both pointers wrap several times at varied fill levels. It also drives the FIFO fully to full and back to empty. Ignored requests at both flags are confirmed by draining and checking that nothing extra or missing comes out.

// File: rtl/gfifo_pkg.sv
package gfifo_pkg;
  typedef logic [31:0] word_t;

  // Gray to binary: each binary bit is the XOR of all Gray bits above and at it
  function automatic word_t gray_to_bin(word_t g);
    word_t b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic word_t bin_to_gray(word_t b);
    return b ^ (b >> 1);
  endfunction

  // Next Gray value for a pointer of width pw
  function automatic word_t gray_step(word_t g, int pw);
    word_t m;
    m = (word_t'(1) << pw) - word_t'(1);
    return bin_to_gray((gray_to_bin(g & m) + word_t'(1)) & m);
  endfunction

  // Memory address from an (aw+1)-bit Gray pointer: fold top bit into next
  function automatic word_t gray_fold(word_t g, int aw);
    word_t r;
    r = g & ((word_t'(1) << aw) - word_t'(1));
    r[aw-1] = g[aw] ^ g[aw-1];
    return r;
  endfunction

  // Remote pointer value that marks a completely filled memory
  function automatic word_t gray_flip_top(word_t g, int aw);
    return g ^ (word_t'(3) << (aw - 1));
  endfunction
endpackage

// File: rtl/gfifo_sync2.sv
module gfifo_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gfifo_gray_ptr.sv
module gfifo_gray_ptr
  import gfifo_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter bit WRITE_SIDE = 1'b1,
  localparam int PW        = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [PW-1:0]     far_ptr,
  output logic [PW-1:0]     ptr_g,
  output logic [ADDR_W-1:0] addr,
  output logic              flag,
  output logic              accept
);
  logic [PW-1:0] ptr_next;

  generate
    if (WRITE_SIDE) begin : g_full
      assign flag = (ptr_g == PW'(gray_flip_top(word_t'(far_ptr), ADDR_W)));
    end else begin : g_empty
      assign flag = (ptr_g == far_ptr);
    end
  endgenerate

  assign accept   = req & ~flag;
  assign ptr_next = PW'(gray_step(word_t'(ptr_g), PW));
  assign addr     = ADDR_W'(gray_fold(word_t'(ptr_g), ADDR_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_g <= '0;
    else if (accept) ptr_g <= ptr_next;
  end
endmodule

// File: rtl/gfifo_dpram.sv
module gfifo_dpram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)  rdata <= '0;
    else if (re)  rdata <= mem[raddr];
  end
endmodule

// File: rtl/gray_fifo_async.sv
module gray_fifo_async #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wr_ptr_g, rd_ptr_g;
  logic [PW-1:0]     rd_ptr_in_wr, wr_ptr_in_rd;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              wr_accept, rd_accept;

  gfifo_gray_ptr #(.ADDR_W(ADDR_W), .WRITE_SIDE(1'b1)) u_wptr (
    .clk(wr_clk), .rst_n(wr_rst_n), .req(wr_en), .far_ptr(rd_ptr_in_wr),
    .ptr_g(wr_ptr_g), .addr(wr_addr), .flag(wr_full), .accept(wr_accept)
  );

  gfifo_gray_ptr #(.ADDR_W(ADDR_W), .WRITE_SIDE(1'b0)) u_rptr (
    .clk(rd_clk), .rst_n(rd_rst_n), .req(rd_en), .far_ptr(wr_ptr_in_rd),
    .ptr_g(rd_ptr_g), .addr(rd_addr), .flag(rd_empty), .accept(rd_accept)
  );

  gfifo_sync2 #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_ptr_g), .q(rd_ptr_in_wr)
  );

  gfifo_sync2 #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_ptr_g), .q(wr_ptr_in_rd)
  );

  gfifo_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .wclk(wr_clk), .we(wr_accept), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rd_rst_n), .re(rd_accept), .raddr(rd_addr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/gray_fifo_async_chk.sv
module gray_fifo_async_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int PW    = ADDR_W + 1
) (
  input logic              wr_clk,
  input logic              wr_rst_n,
  input logic              wr_en,
  input logic              wr_full,
  input logic              rd_clk,
  input logic              rd_rst_n,
  input logic              rd_en,
  input logic              rd_empty,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_accept,
  input logic              rd_accept,
  input logic [PW-1:0]     wr_ptr_g,
  input logic [PW-1:0]     rd_ptr_g
);
  // R2: one bit changes per accepted write / read
  a_r2_wr_gray_step: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_accept |=> $countones(wr_ptr_g ^ $past(wr_ptr_g)) == 1);
  a_r2_rd_gray_step: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_accept |=> $countones(rd_ptr_g ^ $past(rd_ptr_g)) == 1);
  // R2: pointer idle without a request
  a_r2_wr_hold: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_en |=> $stable(wr_ptr_g));
  // R5: write while full ignored
  a_r5_ignore_full: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && wr_full) |=> $stable(wr_ptr_g));
  // R6: read while empty ignored
  a_r6_ignore_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && rd_empty) |=> ($stable(rd_ptr_g) && $stable(rd_data)));
  // R7: output register holds without a read
  a_r7_data_hold: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(rd_data));
  // R9: pointers at zero while in reset
  always @(posedge wr_clk) if (!wr_rst_n) a_r9_wr_reset: assert (wr_ptr_g == '0);
  always @(posedge rd_clk) if (!rd_rst_n) a_r9_rd_reset: assert (rd_ptr_g == '0);
endmodule

bind gray_fifo_async gray_fifo_async_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_full(wr_full),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_empty(rd_empty),
  .rd_data(rd_data), .wr_accept(wr_accept), .rd_accept(rd_accept),
  .wr_ptr_g(wr_ptr_g), .rd_ptr_g(rd_ptr_g)
);

// File: tb/gray_fifo_async_tb.sv
`timescale 1ns/1ps
module gray_fifo_async_tb;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic wr_full, rd_empty;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] sb[$];

  always #2 wr_clk = ~wr_clk;   // 250 MHz
  always #3 rd_clk = ~rd_clk;

  gray_fifo_async #(.DATA_W(DW), .ADDR_W(AW)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: waits for room, writes one word, records it in the scoreboard
  task automatic push(logic [DW-1:0] d);
    @(negedge wr_clk);
    while (wr_full) @(negedge wr_clk);
    wr_en = 1; wr_data = d;
    sb.push_back(d);
    @(posedge wr_clk); #0.5;
    wr_en = 0;
  endtask

  // monitor: waits for data, reads one word, compares with scoreboard head
  task automatic pop(string req);
    logic [DW-1:0] exp;
    @(negedge rd_clk);
    while (rd_empty) @(negedge rd_clk);
    rd_en = 1;
    @(posedge rd_clk); #0.5;
    rd_en = 0;
    exp = (sb.size() > 0) ? sb.pop_front() : 'x;
    check(req, rd_data, exp);
  endtask

  task automatic settle();
    repeat (6) @(posedge rd_clk);
    repeat (6) @(posedge wr_clk);
    #0.5;
  endtask

  task automatic do_reset();
    wr_rst_n = 0; rd_rst_n = 0;
    repeat (3) @(posedge rd_clk);
    #1;
    wr_rst_n = 1; rd_rst_n = 1;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    do_reset();
    // R3 R7 R9: reset state
    check("R3 empty after reset", rd_empty, 1);
    check("R9 full after reset", wr_full, 0);
    check("R7 rd_data after reset", rd_data, 0);

    // R8: empty drops only after synchronisation
    push(8'h11);
    check("R8 empty just after write", rd_empty, 1);
    repeat (4) @(posedge rd_clk);
    #0.5;
    check("R8 empty after sync", rd_empty, 0);
    pop("R1 single word");
    settle();
    check("R3 empty after drain", rd_empty, 1);

    // R6: read while empty ignored
    held = rd_data;
    @(negedge rd_clk); rd_en = 1;
    repeat (5) @(posedge rd_clk);
    #0.5; rd_en = 0;
    check("R6 rd_data held", rd_data, held);
    check("R6 still empty", rd_empty, 1);
    push(8'h5A);
    pop("R6 next word after ignored reads");
    settle();

    // R4 R5: fill to full, attempt overflow, drain
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) check("R4 not full before last", wr_full, 0);
      push(8'h80 + 8'(i));
    end
    check("R4 full after 2^N writes", wr_full, 1);
    @(negedge wr_clk); wr_en = 1; wr_data = 8'hEE;
    repeat (3) @(posedge wr_clk);
    #0.5; wr_en = 0;
    check("R5 full held during overflow", wr_full, 1);
    for (int i = 0; i < DEPTH; i++) pop("R5 drain after overflow");
    settle();
    check("R5 empty after drain", rd_empty, 1);
    check("R4 full cleared", wr_full, 0);

    // R1 R2: long concurrent streams, pointers wrap several times
    fork
      begin
        for (int i = 0; i < 70; i++) begin
          repeat ($urandom_range(0, 3)) @(negedge wr_clk);
          push(8'(i * 7 + 3));
        end
      end
      begin
        for (int i = 0; i < 70; i++) begin
          repeat ($urandom_range(0, 2)) @(negedge rd_clk);
          pop("R1 R2 wrapped stream");
        end
      end
    join
    settle();
    check("R1 scoreboard empty", sb.size(), 0);

    // R9: reset with words stored
    push(8'h01); push(8'h02); push(8'h03);
    settle();
    check("R9 words present before reset", rd_empty, 0);
    sb.delete();
    do_reset();
    check("R9 empty after mid-run reset", rd_empty, 1);
    check("R9 full after mid-run reset", wr_full, 0);
    push(8'h77);
    pop("R9 works after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule